// File: doc/BRIEF.md
# Shadowed Four-Channel Pulse-Width Modulator

The block drives four independent pulse-width outputs from one shared tick enable, nominally 1 MHz. Each channel has a period register, a duty register and a control register. The control register selects a power-of-two prescaler and an output inversion. All three registers sit behind a small memory-mapped port with write and read strobes, a byte address and 32-bit data.

Software may change any setting at any time without glitching the output. Duty and control writes only fill shadow storage. A write to the period register arms the channel. An armed channel copies all three shadow values into its working state together. This happens at the last prescaled step of its running period, or at the next tick if the channel is idle. A period of zero is committed in the same way, so a channel always finishes its current cycle before it stops and holds its output low.

Top module: `pwm_shadow_top`

## Requirements
- R1: Register byte addresses for channel ch (0..3) are period 0x400+4*ch, duty 0x420+4*ch, control 0x440+4*ch; address bits [1:0] must be zero.
- R2: While rdEn is high, rdData combinationally shows the last value written to the addressed register: bits [15:0] for period and duty, bits [1:0] and bit 5 for control, with all other bits zero.
- R3: Control bits [1:0] equal to n divide the tick by 2^n, so one output period lasts period*2^n ticks.
- R4: Within a period, the output is active while the step count (0 to period-1) is below duty. A duty of zero is never active. A duty at or above the period is active for the whole period.
- R5: Control bit 5 set makes the active level low; bit 5 clear makes it high.
- R6: Writes to duty or control, without a period write, never change the running output waveform.
- R7: After a period write, the shadowed period, duty and control are all applied together, starting from the first step after the running period ends.
- R8: An idle channel with a pending period write commits it on the next cycle in which tick is high. A nonzero period then starts at step 0.
- R9: A committed period of zero lets the running period complete. After that the output stays low whatever the polarity.
- R10: Writes to any other address change nothing, and reads from them return zero.
- R11: When a period write falls in the same cycle as an armed commit, the commit uses the shadow values held before that write. The new write stays pending for the next period end.
- R12: After reset, all registers read zero, all channels are idle and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the base PWM rate |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while rdEn is high |
| pwmOut | output | 4 | One PWM output per channel |

## Verification
The critical coincidence is a period-register write landing in the same clock as the end-of-period commit on that channel. The bench provokes it by holding tick high and prescaler at one. It arms a duty change, then times a second period write to the cycle whose step count is period-1. It judges the outcome by counting active cycles over the next 8 and then 24 cycles. Only the ordering "commit the old shadow, keep the new write pending" gives both expected counts. A random phase with a cycle-level reference model also produces such collisions.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CNT_W     = 16;
  localparam int PRE_SEL_W = 2;
  localparam int INV_BIT   = 5;

  // Per-channel view that the register side hands to a counter slice
  typedef struct packed {
    logic                 armed;
    logic [CNT_W-1:0]     per;
    logic [CNT_W-1:0]     dut;
    logic [PRE_SEL_W-1:0] preSel;
    logic                 invert;
  } chanCmd_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int PER_BASE = 'h400,
  parameter int DUT_BASE = 'h420,
  parameter int CTL_BASE = 'h440
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] commit,
  output logic [DATA_W-1:0] rdData,
  output chanCmd_t          cmd [NUM_CH]
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SPAN = NUM_CH * 4;

  logic [CNT_W-1:0]     perReg [NUM_CH];
  logic [CNT_W-1:0]     dutReg [NUM_CH];
  logic [PRE_SEL_W-1:0] selReg [NUM_CH];
  logic                 invReg [NUM_CH];
  logic [NUM_CH-1:0]    armReg;

  logic aligned, perHit, dutHit, ctlHit;
  logic [CH_W-1:0] selCh;
  logic unusedWrBits;

  function automatic logic inGroup(input logic [ADDR_W-1:0] a, input int base);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(base);
    return (a >= ADDR_W'(base)) && (off < ADDR_W'(SPAN));
  endfunction

  // Group bases are 32-byte aligned, so the channel index is read straight off the address
  assign aligned = (addr[1:0] == 2'b00);
  assign perHit  = aligned && inGroup(addr, PER_BASE);
  assign dutHit  = aligned && inGroup(addr, DUT_BASE);
  assign ctlHit  = aligned && inGroup(addr, CTL_BASE);
  assign selCh   = addr[CH_W+1:2];
  assign unusedWrBits = ^{wrData[DATA_W-1:CNT_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armReg <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        perReg[c] <= '0;
        dutReg[c] <= '0;
        selReg[c] <= '0;
        invReg[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        // a period write wins over a commit in the same cycle: it stays pending
        if (wrEn && perHit && selCh == CH_W'(c)) begin
          perReg[c] <= wrData[CNT_W-1:0];
          armReg[c] <= 1'b1;
        end else if (commit[c]) begin
          armReg[c] <= 1'b0;
        end
        if (wrEn && dutHit && selCh == CH_W'(c))
          dutReg[c] <= wrData[CNT_W-1:0];
        if (wrEn && ctlHit && selCh == CH_W'(c)) begin
          selReg[c] <= wrData[PRE_SEL_W-1:0];
          invReg[c] <= wrData[INV_BIT];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      cmd[c].armed  = armReg[c];
      cmd[c].per    = perReg[c];
      cmd[c].dut    = dutReg[c];
      cmd[c].preSel = selReg[c];
      cmd[c].invert = invReg[c];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (perHit) begin
        rdData[CNT_W-1:0] = perReg[selCh];
      end else if (dutHit) begin
        rdData[CNT_W-1:0] = dutReg[selCh];
      end else if (ctlHit) begin
        rdData[PRE_SEL_W-1:0] = selReg[selCh];
        rdData[INV_BIT]       = invReg[selCh];
      end
    end
  end

  // R10: reads that decode to nothing return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !perHit && !dutHit && !ctlHit) |-> (rdData == '0))
    else $error("p_unmapped_zero_r10");

  for (genvar g = 0; g < NUM_CH; g++) begin : g_armChk
    // R6/R7: a period write always leaves the channel armed
    p_arm_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && perHit && selCh == CH_W'(g)) |=> armReg[g])
      else $error("p_arm_after_write_r7");
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  chanCmd_t cmd,
  output logic     commit,
  output logic     pwmOut
);
  localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;

  logic                 running;
  logic [CNT_W-1:0]     actPer, actDut, cnt;
  logic [PRE_SEL_W-1:0] actSel;
  logic                 actInv;
  logic [PRE_CNT_W-1:0] preCnt, preLast;
  logic                 step, lastStep;

  assign preLast  = ~({PRE_CNT_W{1'b1}} << actSel);
  assign step     = running && tick && (preCnt == preLast);
  assign lastStep = step && (cnt == actPer - CNT_W'(1));
  assign commit   = cmd.armed && ((!running && tick) || lastStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      actPer  <= '0;
      actDut  <= '0;
      actSel  <= '0;
      actInv  <= 1'b0;
      cnt     <= '0;
      preCnt  <= '0;
    end else if (commit) begin
      actPer  <= cmd.per;
      actDut  <= cmd.dut;
      actSel  <= cmd.preSel;
      actInv  <= cmd.invert;
      running <= (cmd.per != '0);
      cnt     <= '0;
      preCnt  <= '0;
    end else if (running && tick) begin
      if (step) begin
        preCnt <= '0;
        cnt    <= lastStep ? '0 : cnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_CNT_W'(1);
      end
    end
  end

  assign pwmOut = running && ((cnt < actDut) ^ actInv);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < actPer))
    else $error("p_cnt_range_r4");

  p_prescale_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (preCnt <= preLast))
    else $error("p_prescale_range_r3");

  p_hold_without_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> ($stable(actDut) && $stable(actPer) && $stable(actSel) && $stable(actInv)))
    else $error("p_hold_without_commit_r6");

  p_stop_at_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(lastStep))
    else $error("p_stop_at_boundary_r9");
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCmd_t          cmdBus [NUM_CH];
  logic [NUM_CH-1:0] commitBus;

  pwm_shadow_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .commit(commitBus), .rdData(rdData), .cmd(cmdBus)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_shadow_chan u_chan (
      .clk(clk), .rstN(rstN), .tick(tick), .cmd(cmdBus[g]),
      .commit(commitBus[g]), .pwmOut(pwmOut[g])
    );
  end
endmodule

// File: tb/pwm_shadow_top_bench.sv
module pwm_shadow_top_bench;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NCH-1:0] pwmOut;

  int    nRun = 0, nFail = 0;
  int    tickMode = 1;   // 0 random, 1 always, 2 never, 3 every third, 5 manual
  int    tickPhase = 0;
  bit    done = 1'b0;
  string cmpTag = "R12";

  always #10 clk = ~clk;

  pwm_shadow_top u_pwm_shadow_top (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [15:0] mPer [NCH], mDut [NCH], mAPer [NCH], mADut [NCH], mCnt [NCH];
  logic [1:0]  mSel [NCH], mASel [NCH];
  logic        mInv [NCH], mAInv [NCH], mArm [NCH], mRun [NCH];
  int          mPre [NCH];

  // R1: 1 period, 2 duty, 3 control, 0 unmapped; channel in addr[3:2]
  function automatic int regKind(logic [11:0] a);
    if (a[1:0] != 2'b00 || a[4]) return 0;
    case (a[11:5])
      7'h20:   return 1;
      7'h21:   return 2;
      7'h22:   return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    int c;
    c = int'(a[3:2]);
    case (regKind(a))
      1:       return {16'h0, mPer[c]};
      2:       return {16'h0, mDut[c]};
      3:       return {26'h0, mInv[c], 3'b000, mSel[c]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expOut(int c);
    return mRun[c] && ((mCnt[c] < mADut[c]) ^ mAInv[c]);
  endfunction

  always @(posedge clk) begin
    int wk;
    int wc;
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mPer[c] = 0; mDut[c] = 0; mSel[c] = 0; mInv[c] = 0;
        mAPer[c] = 0; mADut[c] = 0; mASel[c] = 0; mAInv[c] = 0;
        mArm[c] = 0; mRun[c] = 0; mCnt[c] = 0; mPre[c] = 0;
      end
    end else begin
      wk = wrEn ? regKind(addr) : 0;
      wc = int'(addr[3:2]);
      for (int c = 0; c < NCH; c++) begin
        int dv;
        bit endP;
        bit doCommit;
        dv = 1 << mASel[c];
        endP = mRun[c] && tick && (mPre[c] == dv - 1) && (int'(mCnt[c]) == int'(mAPer[c]) - 1);
        doCommit = mArm[c] && ((!mRun[c] && tick) || endP);
        if (doCommit) begin
          mAPer[c] = mPer[c]; mADut[c] = mDut[c]; mASel[c] = mSel[c]; mAInv[c] = mInv[c];
          mRun[c] = (mPer[c] != 0); mCnt[c] = 0; mPre[c] = 0;
        end else if (mRun[c] && tick) begin
          if (mPre[c] == dv - 1) begin
            mPre[c] = 0;
            mCnt[c] = endP ? 16'd0 : mCnt[c] + 16'd1;
          end else begin
            mPre[c] = mPre[c] + 1;
          end
        end
        if (wk == 1 && wc == c) begin mPer[c] = wrData[15:0]; mArm[c] = 1'b1; end
        else if (doCommit) mArm[c] = 1'b0;
        if (wk == 2 && wc == c) mDut[c] = wrData[15:0];
        if (wk == 3 && wc == c) begin mSel[c] = wrData[1:0]; mInv[c] = wrData[5]; end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NCH-1:0] e;
    if (rstN && !done) begin
      for (int c = 0; c < NCH; c++) e[c] = expOut(c);
      chk(cmpTag, {28'h0, pwmOut}, {28'h0, e});
    end
  end

  always @(negedge clk) begin
    case (tickMode)
      0: tick = ($urandom_range(0, 1) == 1);
      1: tick = 1'b1;
      2: tick = 1'b0;
      3: begin tickPhase = (tickPhase + 1) % 3; tick = (tickPhase == 0); end
      default: ;
    endcase
  end

  // all driving tasks start and end on a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(logic [11:0] a, logic [31:0] exp, string tag);
    rdEn = 1'b1; addr = a;
    #1;
    chk(tag, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic countHigh(int c, int n, output int hi);
    hi = 0;
    repeat (n) begin
      hi += int'(pwmOut[c]);
      @(negedge clk);
    end
  endtask

  task automatic setCh(int c, int per, int dut, int ctl);
    wr(12'h440 + 12'(4 * c), 32'(ctl));
    wr(12'h420 + 12'(4 * c), 32'(dut));
    wr(12'h400 + 12'(4 * c), 32'(per));
  endtask

  task automatic waitCnt(int c, int v);
    while (int'(mCnt[c]) != v) @(negedge clk);
  endtask

  function automatic logic [11:0] pickAddr();
    if ($urandom_range(0, 7) == 0) return 12'($urandom);
    return 12'h400 + 12'(32 * $urandom_range(0, 2)) + 12'(4 * $urandom_range(0, 3));
  endfunction

  function automatic logic [31:0] pickData(logic [11:0] a);
    logic [31:0] hi;
    hi = {$urandom, 16'h0} & 32'hFFFF0000;
    case (regKind(a))
      1:       return hi | 32'($urandom_range(0, 12));
      2:       return hi | 32'($urandom_range(0, 14));
      default: return $urandom;
    endcase
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int hi;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk("R12 out in reset", {28'h0, pwmOut}, 32'h0);
    rstN = 1'b1;
    tickMode = 2;
    @(negedge clk);
    chk("R12 out after reset", {28'h0, pwmOut}, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rdChk(12'h400 + 12'(4 * c), 32'h0, "R12 period");
      rdChk(12'h420 + 12'(4 * c), 32'h0, "R12 duty");
      rdChk(12'h440 + 12'(4 * c), 32'h0, "R12 control");
    end

    // R1 / R2: readback with unimplemented bits masked (no ticks, nothing commits)
    cmpTag = "R2";
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] cb;
      cb = 2'(c);
      wr(12'h400 + 12'(4 * c), 32'hFFFF0000 | 32'(16'h1111 * (c + 1)));
      wr(12'h420 + 12'(4 * c), 32'hA5A50100 + 32'(c));
      wr(12'h440 + 12'(4 * c), {26'h3FFFFFF, cb[0], 3'b111, cb});
    end
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] cb;
      cb = 2'(c);
      rdChk(12'h400 + 12'(4 * c), 32'(16'h1111 * (c + 1)), "R1 R2 period");
      rdChk(12'h420 + 12'(4 * c), 32'h00000100 + 32'(c), "R1 R2 duty");
      rdChk(12'h440 + 12'(4 * c), {26'h0, cb[0], 3'b000, cb}, "R1 R2 control");
    end

    // R10: unmapped writes and reads
    cmpTag = "R10";
    wr(12'h410, 32'hFFFFFFFF);
    wr(12'h460, 32'hFFFFFFFF);
    wr(12'h401, 32'hFFFFFFFF);
    wr(12'h3FC, 32'hFFFFFFFF);
    rdChk(12'h410, 32'h0, "R10 read 0x410");
    rdChk(12'h460, 32'h0, "R10 read 0x460");
    rdChk(12'h401, 32'h0, "R10 read 0x401");
    rdChk(12'h3FC, 32'h0, "R10 read 0x3FC");
    rdChk(12'h400, 32'h00001111, "R10 period ch0 kept");
    rdChk(12'h424, 32'h00000101, "R10 duty ch1 kept");
    rdChk(12'h44C, 32'h00000023, "R10 control ch3 kept");

    // park every channel before ticks start
    cmpTag = "R9";
    for (int c = 0; c < NCH; c++) wr(12'h400 + 12'(4 * c), 32'h0);
    tickMode = 1;
    repeat (10) @(negedge clk);
    chk("R9 all idle low", {28'h0, pwmOut}, 32'h0);

    // R8: idle channel starts on the first tick
    cmpTag = "R8";
    tickMode = 5;
    tick = 1'b0;
    setCh(2, 4, 4, 0);
    repeat (5) @(negedge clk);
    chk("R8 no tick stays low", {31'h0, pwmOut[2]}, 32'h0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R8 started after one tick", {31'h0, pwmOut[2]}, 32'h1);
    wr(12'h408, 32'h0);
    tickMode = 1;
    repeat (20) @(negedge clk);

    // R3 / R4 / R5: counts of active cycles over whole periods (tick every cycle)
    cmpTag = "R4";
    setCh(0, 5, 2, 0);    repeat (80) @(negedge clk);
    countHigh(0, 10, hi); chk("R4 per5 dut2", 32'(hi), 32'd4);
    setCh(0, 4, 3, 2);    repeat (80) @(negedge clk);
    countHigh(0, 32, hi); chk("R3 div4 per4 dut3", 32'(hi), 32'd24);
    setCh(0, 3, 7, 1);    repeat (80) @(negedge clk);
    countHigh(0, 12, hi); chk("R4 duty above period", 32'(hi), 32'd12);
    setCh(0, 6, 0, 0);    repeat (80) @(negedge clk);
    countHigh(0, 12, hi); chk("R4 duty zero", 32'(hi), 32'd0);
    setCh(0, 5, 2, 'h20); repeat (80) @(negedge clk);
    countHigh(0, 10, hi); chk("R5 inverted", 32'(hi), 32'd6);
    setCh(0, 2, 1, 3);    repeat (80) @(negedge clk);
    countHigh(0, 32, hi); chk("R3 div8 per2 dut1", 32'(hi), 32'd16);

    // R6 / R7: shadowed duty and control
    cmpTag = "R6";
    setCh(1, 10, 5, 0);   repeat (40) @(negedge clk);
    countHigh(1, 10, hi); chk("R6 baseline", 32'(hi), 32'd5);
    wr(12'h424, 32'h0);
    wr(12'h444, 32'h20);
    repeat (40) @(negedge clk);
    countHigh(1, 10, hi); chk("R6 shadow held", 32'(hi), 32'd5);
    cmpTag = "R7";
    wr(12'h404, 32'd10);
    repeat (25) @(negedge clk);
    countHigh(1, 10, hi); chk("R7 duty and polarity together", 32'(hi), 32'd10);

    // R9: disable completes the running period, then low though inverted
    cmpTag = "R9";
    waitCnt(1, 2);
    wr(12'h404, 32'h0);
    countHigh(1, 7, hi);  chk("R9 period completes", 32'(hi), 32'd7);
    countHigh(1, 20, hi); chk("R9 low after stop", 32'(hi), 32'd0);
    rdChk(12'h404, 32'h0, "R9 period reads zero");

    // R11: period write coinciding with an armed commit
    cmpTag = "R11";
    setCh(3, 8, 8, 0);
    repeat (30) @(negedge clk);
    waitCnt(3, 1);
    wr(12'h42C, 32'd2);
    wr(12'h40C, 32'd8);
    waitCnt(3, 7);
    wr(12'h40C, 32'd6);
    countHigh(3, 8, hi);  chk("R11 old shadow committed", 32'(hi), 32'd2);
    countHigh(3, 24, hi); chk("R11 new write kept pending", 32'(hi), 32'd8);

    // random mix checked against the model every cycle
    cmpTag = "R7 random";
    tickMode = 0;
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [11:0] a;
      r = $urandom_range(0, 9);
      a = pickAddr();
      if (r < 3) wr(a, pickData(a));
      else if (r < 5) rdChk(a, expRead(a), "R2 random read");
      else @(negedge clk);
      if (i == 3000) tickMode = 3;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule